// File: doc/BRIEF.md
# Processor Clock-Stop Power State Controller

This block tracks the power state of a processor core as the system stops and restarts its clock, as the core halts, and as external agents snoop or flush the cache while the core sleeps. It receives a stop-clock request, a halt strobe from the execution unit, wake events, snoop and bus-arbitration strobes, a flush request, and status from the cache write-back path. It also receives an indication of whether the clock is running.

Its outputs are single-cycle requests to the bus-cycle engine for a stop-grant or halt special cycle, a bus-float control, a modified-hit flag and the present state. A special cycle is requested according to the state being left. Snoop and flush excursions return to a remembered state. A snoop never causes a cycle on its return. A flush back into halt asks for the halt cycle again.

All outputs except `bus_float_o` are registered. A transition seen on the inputs at one rising edge shows on `state_o` and on the pulse outputs straight after that edge.

Top module: `pwr_state_ctrl`

## Requirements
- R1: `state_o` encodes Normal=0, Auto-Halt=1, Stop Grant=2, Stop Clock=3, Snoop=4, Flush=5. In Normal, a high `stpclk_req_i` moves the controller to Stop Grant and raises `sg_cycle_o` for that one cycle. In Normal the stop-clock request wins over a flush request, and a flush request wins over a halt strobe.
- R2: In Stop Grant, with the stop-clock request still high, a low `clk_run_i` moves the controller to Stop Clock. Stop Clock is entered from no other state. In Stop Clock a high `clk_run_i` returns the controller to Stop Grant with no special-cycle pulse.
- R3: In Normal, a `halt_i` strobe moves the controller to Auto-Halt and raises `halt_cycle_o` for one cycle. Auto-Halt exits to Normal only when any of `intr_i`, `nmi_i`, `smi_i` or `sreset_i` is high, and that exit issues no pulse.
- R4: In Auto-Halt, a stop-clock request moves the controller to Stop Grant with an `sg_cycle_o` pulse. When the request drops, the controller goes back to Auto-Halt with a new `halt_cycle_o` pulse. A Stop Grant entered from Normal goes back to Normal with no pulse. In Auto-Halt a wake event wins over a simultaneous stop-clock request.
- R5: `bus_float_o` is high exactly when any of `hold_i`, `ahold_i` or `boff_i` is high and the state is Auto-Halt or Stop Grant.
- R6: In Auto-Halt or Stop Grant, `eads_i` moves the controller to Snoop. Without a modified hit it stays there exactly one cycle, then returns to the state it came from with no pulse.
- R7: If `mod_hit_i` is high together with `eads_i`, `hitm_o` is high for the whole snoop. The controller stays in Snoop until `wb_done_i` is seen, then returns to the prior state with `hitm_o` low and no pulse.
- R8: A flush request enters Flush only from Normal or Auto-Halt, and only with `wb_mode_i` high. It is ignored otherwise. `wb_done_i` returns the controller to the prior state, with a `halt_cycle_o` pulse when that state is Auto-Halt.
- R9: `intr_i` seen in Stop Clock sets `intr_pend_o`. The flag stays set while `intr_i` is held and clears when `intr_i` drops or Normal is reached. An interrupt still held after the clock resumes wakes Auto-Halt normally.
- R10: A high `reset_i` moves the controller to Normal at the next edge, whatever the other inputs are, and clears every pulse, `hitm_o` and `intr_pend_o`. A low `rst_ni` does the same asynchronously.
- R11: `sg_cycle_o` and `halt_cycle_o` are never high in the same cycle, and each is high for one cycle per transition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reset_i | input | 1 | Synchronous hard reset event |
| stpclk_req_i | input | 1 | Stop-clock request, level |
| halt_i | input | 1 | Halt instruction executed, strobe |
| intr_i | input | 1 | Maskable interrupt |
| nmi_i | input | 1 | Non-maskable interrupt |
| smi_i | input | 1 | System management interrupt |
| sreset_i | input | 1 | Soft reset event |
| eads_i | input | 1 | External snoop address strobe |
| hold_i | input | 1 | Bus hold request |
| ahold_i | input | 1 | Address hold request |
| boff_i | input | 1 | Bus back-off |
| flush_i | input | 1 | Cache flush request |
| wb_mode_i | input | 1 | Cache in write-back mode |
| mod_hit_i | input | 1 | Snoop hit a modified line |
| wb_done_i | input | 1 | Write-back or flush completed |
| clk_run_i | input | 1 | Core clock running |
| sg_cycle_o | output | 1 | Stop-grant special cycle request pulse |
| halt_cycle_o | output | 1 | Halt special cycle request pulse |
| bus_float_o | output | 1 | Float the bus |
| hitm_o | output | 1 | Modified line hit during snoop |
| intr_pend_o | output | 1 | Interrupt seen while clock stopped |
| state_o | output | 3 | Current power state |

## Verification
The bench goes after return paths that depend on where a state was entered from. A design that keeps no return target would leave a snoop taken during a halt-origin Stop Grant in the wrong state. It would also miss the halt cycle after the request drops, or send a flush back to Normal when it came from Auto-Halt. The bench sweeps every combination of wake events and bus-hold strobes across the states. Wrong wake decoding would leave Auto-Halt on a zero vector or stay in it on a single event, and a float decoded from the wrong states would show at the port. The bench also checks that a snoop with a modified hit holds until completion rather than one cycle, that a flush with write-back mode off is ignored, and that a stop-clock request collides correctly with a wake event or a reset.

// File: rtl/pwr_state_pkg.sv
package pwr_state_pkg;
  localparam int STATE_W = 3;

  typedef enum logic [STATE_W-1:0] {
    ST_NORMAL = 3'd0,
    ST_HALT   = 3'd1,
    ST_SGRANT = 3'd2,
    ST_SCLK   = 3'd3,
    ST_SNOOP  = 3'd4,
    ST_FLUSH  = 3'd5
  } pwr_state_e;
endpackage

// File: rtl/pwr_evt_arb.sv
module pwr_evt_arb
  import pwr_state_pkg::*;
(
  input  logic       intr_i,
  input  logic       nmi_i,
  input  logic       smi_i,
  input  logic       sreset_i,
  input  logic       eads_i,
  input  logic       hold_i,
  input  logic       ahold_i,
  input  logic       boff_i,
  input  logic       flush_i,
  input  logic       wb_mode_i,
  input  pwr_state_e state_i,
  output logic       wake_o,
  output logic       snoop_o,
  output logic       flush_ok_o,
  output logic       bus_float_o
);
  logic asleep;

  assign asleep      = (state_i == ST_HALT) || (state_i == ST_SGRANT);
  assign wake_o      = intr_i | nmi_i | smi_i | sreset_i;
  assign snoop_o     = eads_i;
  assign flush_ok_o  = flush_i & wb_mode_i;
  assign bus_float_o = asleep & (hold_i | ahold_i | boff_i);
endmodule

// File: rtl/pwr_fsm.sv
module pwr_fsm
  import pwr_state_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reset_i,
  input  logic       stpclk_i,
  input  logic       halt_i,
  input  logic       wake_i,
  input  logic       snoop_i,
  input  logic       flush_ok_i,
  input  logic       hitm_i,
  input  logic       wb_done_i,
  input  logic       clk_run_i,
  output pwr_state_e state_o,
  output logic       snoop_enter_o,
  output logic       sg_cycle_o,
  output logic       halt_cycle_o
);
  pwr_state_e state_q, state_d;
  pwr_state_e prior_q, prior_d;  // return target of snoop / flush
  pwr_state_e sgret_q, sgret_d;  // return target of stop grant
  logic       sg_d, halt_d, sg_q, halt_q;

  always_comb begin
    state_d       = state_q;
    prior_d       = prior_q;
    sgret_d       = sgret_q;
    sg_d          = 1'b0;
    halt_d        = 1'b0;
    snoop_enter_o = 1'b0;
    if (reset_i) begin
      state_d = ST_NORMAL;
      prior_d = ST_NORMAL;
      sgret_d = ST_NORMAL;
    end else begin
      unique case (state_q)
        ST_NORMAL: begin
          if (stpclk_i) begin
            state_d = ST_SGRANT;
            sgret_d = ST_NORMAL;
            sg_d    = 1'b1;
          end else if (flush_ok_i) begin
            state_d = ST_FLUSH;
            prior_d = ST_NORMAL;
          end else if (halt_i) begin
            state_d = ST_HALT;
            halt_d  = 1'b1;
          end
        end
        ST_HALT: begin
          if (wake_i) begin
            state_d = ST_NORMAL;
          end else if (stpclk_i) begin
            state_d = ST_SGRANT;
            sgret_d = ST_HALT;
            sg_d    = 1'b1;
          end else if (snoop_i) begin
            state_d       = ST_SNOOP;
            prior_d       = ST_HALT;
            snoop_enter_o = 1'b1;
          end else if (flush_ok_i) begin
            state_d = ST_FLUSH;
            prior_d = ST_HALT;
          end
        end
        ST_SGRANT: begin
          if (!stpclk_i) begin
            state_d = sgret_q;
            halt_d  = (sgret_q == ST_HALT);
          end else if (!clk_run_i) begin
            state_d = ST_SCLK;
          end else if (snoop_i) begin
            state_d       = ST_SNOOP;
            prior_d       = ST_SGRANT;
            snoop_enter_o = 1'b1;
          end
        end
        ST_SCLK: begin
          if (clk_run_i) state_d = ST_SGRANT;
        end
        ST_SNOOP: begin
          if (!hitm_i || wb_done_i) state_d = prior_q;
        end
        ST_FLUSH: begin
          if (wb_done_i) begin
            state_d = prior_q;
            halt_d  = (prior_q == ST_HALT);
          end
        end
        default: state_d = ST_NORMAL;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NORMAL;
      prior_q <= ST_NORMAL;
      sgret_q <= ST_NORMAL;
      sg_q    <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      prior_q <= prior_d;
      sgret_q <= sgret_d;
      sg_q    <= sg_d;
      halt_q  <= halt_d;
    end
  end

  assign state_o      = state_q;
  assign sg_cycle_o   = sg_q;
  assign halt_cycle_o = halt_q;
endmodule

// File: rtl/pwr_track.sv
module pwr_track
  import pwr_state_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reset_i,
  input  logic       snoop_enter_i,
  input  logic       mod_hit_i,
  input  logic       wb_done_i,
  input  logic       intr_i,
  input  pwr_state_e state_i,
  output logic       hitm_o,
  output logic       intr_pend_o
);
  logic hitm_q, pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hitm_q <= 1'b0;
      pend_q <= 1'b0;
    end else if (reset_i) begin
      hitm_q <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      if (snoop_enter_i)         hitm_q <= mod_hit_i;
      else if (hitm_q && wb_done_i) hitm_q <= 1'b0;
      pend_q <= intr_i && (pend_q || state_i == ST_SCLK) && (state_i != ST_NORMAL);
    end
  end

  assign hitm_o      = hitm_q;
  assign intr_pend_o = pend_q;
endmodule

// File: rtl/pwr_state_ctrl.sv
module pwr_state_ctrl
  import pwr_state_pkg::*;
(
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reset_i,
  input  logic               stpclk_req_i,
  input  logic               halt_i,
  input  logic               intr_i,
  input  logic               nmi_i,
  input  logic               smi_i,
  input  logic               sreset_i,
  input  logic               eads_i,
  input  logic               hold_i,
  input  logic               ahold_i,
  input  logic               boff_i,
  input  logic               flush_i,
  input  logic               wb_mode_i,
  input  logic               mod_hit_i,
  input  logic               wb_done_i,
  input  logic               clk_run_i,
  output logic               sg_cycle_o,
  output logic               halt_cycle_o,
  output logic               bus_float_o,
  output logic               hitm_o,
  output logic               intr_pend_o,
  output logic [STATE_W-1:0] state_o
);
  pwr_state_e state;
  logic wake, snoop, flush_ok, snoop_enter, hitm;

  pwr_evt_arb i_arb (
    .intr_i      (intr_i),
    .nmi_i       (nmi_i),
    .smi_i       (smi_i),
    .sreset_i    (sreset_i),
    .eads_i      (eads_i),
    .hold_i      (hold_i),
    .ahold_i     (ahold_i),
    .boff_i      (boff_i),
    .flush_i     (flush_i),
    .wb_mode_i   (wb_mode_i),
    .state_i     (state),
    .wake_o      (wake),
    .snoop_o     (snoop),
    .flush_ok_o  (flush_ok),
    .bus_float_o (bus_float_o)
  );

  pwr_fsm i_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .reset_i       (reset_i),
    .stpclk_i      (stpclk_req_i),
    .halt_i        (halt_i),
    .wake_i        (wake),
    .snoop_i       (snoop),
    .flush_ok_i    (flush_ok),
    .hitm_i        (hitm),
    .wb_done_i     (wb_done_i),
    .clk_run_i     (clk_run_i),
    .state_o       (state),
    .snoop_enter_o (snoop_enter),
    .sg_cycle_o    (sg_cycle_o),
    .halt_cycle_o  (halt_cycle_o)
  );

  pwr_track i_track (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .reset_i       (reset_i),
    .snoop_enter_i (snoop_enter),
    .mod_hit_i     (mod_hit_i),
    .wb_done_i     (wb_done_i),
    .intr_i        (intr_i),
    .state_i       (state),
    .hitm_o        (hitm),
    .intr_pend_o   (intr_pend_o)
  );

  assign hitm_o  = hitm;
  assign state_o = state;
endmodule

// File: rtl/pwr_state_ctrl_chk.sv
module pwr_state_ctrl_chk
  import pwr_state_pkg::*;
(
  input logic               clk_i,
  input logic               rst_ni,
  input logic               reset_i,
  input logic               hold_i,
  input logic               ahold_i,
  input logic               boff_i,
  input logic               sg_cycle_o,
  input logic               halt_cycle_o,
  input logic               bus_float_o,
  input logic               hitm_o,
  input logic               intr_pend_o,
  input logic [STATE_W-1:0] state_o
);
  a_r1_sg_from_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sg_cycle_o |-> (state_o == ST_SGRANT) &&
                   ($past(state_o) == ST_NORMAL || $past(state_o) == ST_HALT));

  a_r2_sclk_from_sg: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SCLK && $past(state_o) != ST_SCLK) |-> $past(state_o) == ST_SGRANT);

  a_r2_no_sg_on_resume: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_SGRANT && ($past(state_o) == ST_SCLK || $past(state_o) == ST_SNOOP))
      |-> !sg_cycle_o);

  a_r3_halt_pulse_state: assert property (@(posedge clk_i) disable iff (!rst_ni)
    halt_cycle_o |-> state_o == ST_HALT);

  a_r5_float_states: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bus_float_o |-> (hold_i || ahold_i || boff_i) &&
                    (state_o == ST_HALT || state_o == ST_SGRANT));

  a_r7_hitm_in_snoop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hitm_o |-> state_o == ST_SNOOP);

  a_r8_flush_entry: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == ST_FLUSH && $past(state_o) != ST_FLUSH) |->
      ($past(state_o) == ST_NORMAL || $past(state_o) == ST_HALT));

  a_r10_sync_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reset_i |=> state_o == ST_NORMAL && !sg_cycle_o && !halt_cycle_o &&
                !hitm_o && !intr_pend_o);

  a_r11_one_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sg_cycle_o, halt_cycle_o}));

  a_r11_sg_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sg_cycle_o |=> !sg_cycle_o);
endmodule

bind pwr_state_ctrl pwr_state_ctrl_chk i_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reset_i      (reset_i),
  .hold_i       (hold_i),
  .ahold_i      (ahold_i),
  .boff_i       (boff_i),
  .sg_cycle_o   (sg_cycle_o),
  .halt_cycle_o (halt_cycle_o),
  .bus_float_o  (bus_float_o),
  .hitm_o       (hitm_o),
  .intr_pend_o  (intr_pend_o),
  .state_o      (state_o)
);

// File: tb/test_pwr_state_ctrl.sv
module test_pwr_state_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int S_NOR = 0, S_HLT = 1, S_SG = 2, S_SCK = 3, S_SNP = 4, S_FL = 5;

  logic clk = 1'b0, rst_ni = 1'b0, reset_i = 1'b0;
  logic stpclk_req_i = 1'b0, halt_i = 1'b0;
  logic intr_i = 1'b0, nmi_i = 1'b0, smi_i = 1'b0, sreset_i = 1'b0;
  logic eads_i = 1'b0, hold_i = 1'b0, ahold_i = 1'b0, boff_i = 1'b0;
  logic flush_i = 1'b0, wb_mode_i = 1'b0, mod_hit_i = 1'b0, wb_done_i = 1'b0;
  logic clk_run_i = 1'b1;
  logic sg_cycle_o, halt_cycle_o, bus_float_o, hitm_o, intr_pend_o;
  logic [2:0] state_o;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_state_ctrl i_pwr_state_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .reset_i(reset_i),
    .stpclk_req_i(stpclk_req_i), .halt_i(halt_i),
    .intr_i(intr_i), .nmi_i(nmi_i), .smi_i(smi_i), .sreset_i(sreset_i),
    .eads_i(eads_i), .hold_i(hold_i), .ahold_i(ahold_i), .boff_i(boff_i),
    .flush_i(flush_i), .wb_mode_i(wb_mode_i), .mod_hit_i(mod_hit_i),
    .wb_done_i(wb_done_i), .clk_run_i(clk_run_i),
    .sg_cycle_o(sg_cycle_o), .halt_cycle_o(halt_cycle_o),
    .bus_float_o(bus_float_o), .hitm_o(hitm_o), .intr_pend_o(intr_pend_o),
    .state_o(state_o)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // state plus both pulses
  task automatic expect_out(input string req, input int st, input int sg, input int hl);
    check({req, " state"}, int'(state_o), st);
    check({req, " sg_cycle"}, int'(sg_cycle_o), sg);
    check({req, " halt_cycle"}, int'(halt_cycle_o), hl);
  endtask

  task automatic go_halt();
    halt_i = 1'b1; tick(); halt_i = 1'b0;
    check("R3 enter halt", int'(state_o), S_HLT);
    tick();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    checks++;
    failures++;
    $display("FAIL watchdog actual=1 expected=0");
    summary();
  end

  initial begin
    // R10 async reset
    #3;
    expect_out("R10 async reset", S_NOR, 0, 0);
    check("R10 hitm reset", int'(hitm_o), 0);
    tick(); tick();
    rst_ni = 1'b1;
    tick();
    expect_out("R10 after release", S_NOR, 0, 0);

    // R1 and R11: normal to stop grant
    stpclk_req_i = 1'b1; tick();
    expect_out("R1 sg entry", S_SG, 1, 0);
    tick();
    expect_out("R11 sg single pulse", S_SG, 0, 0);
    stpclk_req_i = 1'b0; tick();
    expect_out("R4 sg back to normal", S_NOR, 0, 0);

    // R1 priority in normal
    stpclk_req_i = 1'b1; flush_i = 1'b1; wb_mode_i = 1'b1; halt_i = 1'b1; tick();
    expect_out("R1 stpclk over flush/halt", S_SG, 1, 0);
    stpclk_req_i = 1'b0; tick();
    expect_out("R1 return", S_NOR, 0, 0);
    tick();
    expect_out("R1 flush over halt", S_FL, 0, 0);
    flush_i = 1'b0; halt_i = 1'b0; wb_done_i = 1'b1; tick(); wb_done_i = 1'b0;
    expect_out("R8 flush done to normal", S_NOR, 0, 0);

    // R3 wake sweep over all 16 combinations
    for (int v = 0; v < 16; v++) begin
      go_halt();
      {intr_i, nmi_i, smi_i, sreset_i} = 4'(v);
      tick();
      expect_out("R3 wake sweep", (v != 0) ? S_NOR : S_HLT, 0, 0);
      {intr_i, nmi_i, smi_i, sreset_i} = 4'b0;
      if (v == 0) begin
        nmi_i = 1'b1; tick(); nmi_i = 1'b0;
      end
      check("R3 back to normal", int'(state_o), S_NOR);
    end
    // wake event in normal is ignored
    nmi_i = 1'b1; smi_i = 1'b1; tick(); nmi_i = 1'b0; smi_i = 1'b0;
    expect_out("R3 wake ignored in normal", S_NOR, 0, 0);

    // R4 halt to stop grant and back
    go_halt();
    stpclk_req_i = 1'b1; tick();
    expect_out("R4 halt to sg", S_SG, 1, 0);
    stpclk_req_i = 1'b0; tick();
    expect_out("R4 sg back to halt", S_HLT, 0, 1);
    tick();
    expect_out("R11 halt single pulse", S_HLT, 0, 0);
    stpclk_req_i = 1'b1; intr_i = 1'b1; tick();
    expect_out("R4 wake beats stpclk", S_NOR, 0, 0);
    intr_i = 1'b0; tick();
    expect_out("R4 normal then sg", S_SG, 1, 0);
    stpclk_req_i = 1'b0; tick();

    // R2 stop clock and resume
    stpclk_req_i = 1'b1; tick(); tick();
    clk_run_i = 1'b0; tick();
    expect_out("R2 sg to sclk", S_SCK, 0, 0);
    tick();
    check("R2 sclk holds", int'(state_o), S_SCK);
    clk_run_i = 1'b1; tick();
    expect_out("R2 resume no pulse", S_SG, 0, 0);
    stpclk_req_i = 1'b0; tick();
    check("R2 back to normal", int'(state_o), S_NOR);
    clk_run_i = 1'b0; tick();
    check("R2 no sclk from normal", int'(state_o), S_NOR);
    clk_run_i = 1'b1;

    // R9 interrupt while clock stopped, halt origin
    go_halt();
    stpclk_req_i = 1'b1; tick();
    clk_run_i = 1'b0; tick();
    check("R9 in sclk", int'(state_o), S_SCK);
    intr_i = 1'b1; tick();
    check("R9 pend set", int'(intr_pend_o), 1);
    clk_run_i = 1'b1; tick();
    check("R9 pend kept", int'(intr_pend_o), 1);
    stpclk_req_i = 1'b0; tick();
    expect_out("R9 halt re-entry", S_HLT, 0, 1);
    tick();
    expect_out("R9 held intr wakes", S_NOR, 0, 0);
    tick();
    check("R9 pend clear at normal", int'(intr_pend_o), 0);
    intr_i = 1'b0;
    // pend clears when intr drops
    stpclk_req_i = 1'b1; tick(); clk_run_i = 1'b0; tick();
    intr_i = 1'b1; tick();
    check("R9 pend set again", int'(intr_pend_o), 1);
    intr_i = 1'b0; tick();
    check("R9 pend clear on drop", int'(intr_pend_o), 0);
    clk_run_i = 1'b1; tick(); stpclk_req_i = 1'b0; tick();
    check("R9 normal", int'(state_o), S_NOR);

    // R5 float sweep over states normal, halt, sg
    for (int s = 0; s < 3; s++) begin
      if (s == 1) go_halt();
      if (s == 2) begin stpclk_req_i = 1'b1; tick(); end
      for (int v = 0; v < 8; v++) begin
        {hold_i, ahold_i, boff_i} = 3'(v);
        #1;
        check("R5 float sweep", int'(bus_float_o), ((v != 0) && (s != 0)) ? 1 : 0);
      end
      {hold_i, ahold_i, boff_i} = 3'b0;
    end
    clk_run_i = 1'b0; tick();
    hold_i = 1'b1; #1;
    check("R5 no float in sclk", int'(bus_float_o), 0);
    hold_i = 1'b0; clk_run_i = 1'b1; tick();
    check("R5 resumed sg", int'(state_o), S_SG);

    // R6 snoop from halt-origin sg, then from halt
    eads_i = 1'b1; tick(); eads_i = 1'b0;
    expect_out("R6 snoop from sg", S_SNP, 0, 0);
    check("R6 no hitm", int'(hitm_o), 0);
    tick();
    expect_out("R6 return sg", S_SG, 0, 0);
    stpclk_req_i = 1'b0; tick();
    expect_out("R6 sg still returns halt", S_HLT, 0, 1);
    eads_i = 1'b1; tick(); eads_i = 1'b0;
    expect_out("R6 snoop from halt", S_SNP, 0, 0);
    tick();
    expect_out("R6 return halt", S_HLT, 0, 0);

    // R7 modified hit during snoop from sg
    stpclk_req_i = 1'b1; tick();
    eads_i = 1'b1; mod_hit_i = 1'b1; tick(); eads_i = 1'b0; mod_hit_i = 1'b0;
    check("R7 hitm set", int'(hitm_o), 1);
    tick(); tick();
    expect_out("R7 held in snoop", S_SNP, 0, 0);
    check("R7 hitm held", int'(hitm_o), 1);
    wb_done_i = 1'b1; tick(); wb_done_i = 1'b0;
    expect_out("R7 return sg", S_SG, 0, 0);
    check("R7 hitm clear", int'(hitm_o), 0);

    // R8 flush ignored in sg, then flush from halt
    flush_i = 1'b1; wb_mode_i = 1'b1; tick();
    check("R8 flush ignored in sg", int'(state_o), S_SG);
    flush_i = 1'b0; stpclk_req_i = 1'b0; tick();
    check("R8 halt again", int'(state_o), S_HLT);
    flush_i = 1'b1; wb_mode_i = 1'b0; tick();
    check("R8 flush ignored no wb", int'(state_o), S_HLT);
    wb_mode_i = 1'b1; tick(); flush_i = 1'b0;
    expect_out("R8 flush from halt", S_FL, 0, 0);
    tick();
    check("R8 flush waits", int'(state_o), S_FL);
    wb_done_i = 1'b1; tick(); wb_done_i = 1'b0;
    expect_out("R8 flush back to halt", S_HLT, 0, 1);

    // R10 sync reset beats everything
    stpclk_req_i = 1'b1; tick();
    eads_i = 1'b1; mod_hit_i = 1'b1; tick(); eads_i = 1'b0; mod_hit_i = 1'b0;
    check("R10 pre hitm", int'(hitm_o), 1);
    reset_i = 1'b1; tick();
    expect_out("R10 sync reset", S_NOR, 0, 0);
    check("R10 hitm cleared", int'(hitm_o), 0);
    tick();
    expect_out("R10 reset over stpclk", S_NOR, 0, 0);
    reset_i = 1'b0; stpclk_req_i = 1'b0; tick();
    check("R10 idle after reset", int'(state_o), S_NOR);

    summary();
  end
endmodule